// File: doc/BRIEF.md
# Five-Channel Edge-Triggered Interrupt Latch Bank

This block is the interrupt front end for five port pins. When the interrupt mode input is low, the pins behave as plain I/O. Reads return the synchronized pin levels, the output enables follow the direction register, and every interrupt latch is held at zero. When the interrupt mode input is high, each synchronized pin goes through an XOR with a polarity bit and then into a falling-edge detector. A detected edge sets that channel's interrupt latch. Channels 0 to 2 have their polarity fixed at 0, so they react only to falling pins. Channels 3 and 4 take their polarity from two control inputs, so each of them can also be set to react to rising pins.

A latch clears in three ways. Leaving interrupt mode clears it. Writing a 0 to its bit of the port data register clears it, and this takes effect in the cycle after the write strobe ends. A push strobe clears it while the channel's acknowledge input differs from the latch state. If a set and a clear arrive in the same cycle, the latch sets. In interrupt mode the direction register becomes the per-channel interrupt mask: a channel requests service, active low, only when its latch and its direction bit are both 1. The pin output drivers are turned off in interrupt mode. The single-cycle edge pulses of channels 3 and 4 are also driven out for neighbouring handshake logic.

Top module: `intr_latch_bank`

## Requirements
- R1: After the synchronous active-high reset, all latches are 0 and all request outputs are 1. Reading in interrupt mode then returns 5'b00000.
- R2: With mode_irq low, falling pins set no latch. rd_data returns the pin levels two clocks after they change.
- R3: With mode_irq high, a falling pin on channels 0 to 2 sets that latch. The latch bit appears on rd_data three clocks after the pin is driven. A rising pin sets nothing.
- R4: For channel 3 (pol_sel bit 0) and channel 4 (pol_sel bit 1), a polarity bit of 1 makes a rising pin set the latch. With that polarity bit at 1, a falling pin sets nothing.
- R5: Changing a polarity bit from 0 to 1 while the pin is high counts as an edge and sets the latch two clocks after the change.
- R6: edge3_pulse and edge4_pulse are high for exactly one clock per detected edge. For a pin change this is the clock two cycles after the pin is driven.
- R7: A data write (dat_wr held high, then low) clears every latch whose written bit is 0, in the first clock after dat_wr falls. Latches whose written bit is 1 are unchanged.
- R8: While push_n is low, a latch is cleared when its ack bit differs from the latch state. Latches whose ack bit equals their state are unchanged, and while push_n is high ack has no effect.
- R9: A set and a clear in the same clock leave the latch at 1.
- R10: req_n[i] is 0 exactly when latch i and direction bit i are both 1. A direction write takes effect one clock later.
- R11: Dropping mode_irq clears all latches within one clock.
- R12: pad_oe equals the direction register when mode_irq is low and is 0 when it is high. pad_out holds the last data written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_irq | input | 1 | 1 selects interrupt mode, 0 selects plain I/O |
| pin_in | input | 5 | Asynchronous pin levels |
| pol_sel | input | 2 | Edge polarity for channels 3 and 4 (1 = rising) |
| dir_wr | input | 1 | Direction register write enable |
| dir_data | input | 5 | Direction / mask data |
| dat_wr | input | 1 | Data register write strobe (level) |
| dat_data | input | 5 | Data register write value |
| push_n | input | 1 | Push strobe, active low |
| ack | input | 5 | Per-channel acknowledge compared with latch state |
| rd_data | output | 5 | Latch states in interrupt mode, pin levels otherwise |
| req_n | output | 5 | Masked interrupt requests, active low |
| edge3_pulse | output | 1 | Channel 3 edge pulse |
| edge4_pulse | output | 1 | Channel 4 edge pulse |
| pad_oe | output | 5 | Pin output enables |
| pad_out | output | 5 | Pin output data |

## Verification
A latch that is wrongly set or left uncleared shows up on rd_data and req_n one clock after the event that should have moved it. A bad edge detector shows up on the channel 3 and 4 pulse outputs two clocks after a pin change, or one clock after a polarity change. The bench therefore samples rd_data and the pulse outputs at those exact cycles. Doing so exposes timing shifts as well as wrong values. It also checks that clear-only stimulus leaves the untargeted channels at their earlier state.

// File: rtl/ilb_pkg.sv
package ilb_pkg;
  parameter int unsigned ILB_CH = 5;

  // level seen by the falling-edge detector
  function automatic logic sense_level(input logic pin, input logic pol);
    return pin ^ pol;
  endfunction

  // active-low masked request
  function automatic logic req_level_n(input logic latched, input logic enable);
    return !(latched && enable);
  endfunction
endpackage

// File: rtl/ilb_sync.sv
module ilb_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ilb_edge_cell.sv
module ilb_edge_cell
  import ilb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic pin_s,
  input  logic pol,
  output logic pulse
);
  logic lvl;
  logic lvl_q;

  assign lvl = sense_level(pin_s, pol);

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign pulse = enable && lvl_q && !lvl;

  // R6: an edge pulse never lasts two clocks
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/ilb_latch_cell.sv
module ilb_latch_cell (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic set_ev,
  input  logic clr_wr,
  input  logic clr_push,
  output logic q
);
  logic q_next;

  always_comb begin
    q_next = q;
    if (!enable)                q_next = 1'b0;
    else if (set_ev)            q_next = 1'b1;
    else if (clr_wr || clr_push) q_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end

  // R9: set wins over a same-cycle clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (enable && set_ev) |=> q);
  // R11: mode 0 empties the latch
  assert_mode0_clear_R11: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !q);
  // R7: write clear takes effect when no set competes
  assert_write_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !set_ev) |=> !q);
  // R8: push clear takes effect when no set competes
  assert_push_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_push && !set_ev) |=> !q);
endmodule

// File: rtl/ilb_wr_clear.sv
module ilb_wr_clear #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] clr
);
  logic             wr_q;
  logic [WIDTH-1:0] cap_q;
  logic             wr_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      cap_q  <= '0;
      data_q <= '0;
    end else begin
      wr_q <= wr;
      if (wr) begin
        cap_q  <= wdata;
        data_q <= wdata;
      end
    end
  end

  assign wr_fall = wr_q && !wr;
  assign clr     = wr_fall ? ~cap_q : '0;

  // R7: the clear vector is a single-cycle event
  assert_clear_single_R7: assert property (@(posedge clk) disable iff (rst)
    (clr != '0) |=> (clr == '0));
endmodule

// File: rtl/intr_latch_bank.sv
module intr_latch_bank
  import ilb_pkg::*;
#(
  parameter int unsigned CH          = ILB_CH,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned POL_BASE    = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mode_irq,
  input  logic [CH-1:0]          pin_in,
  input  logic [CH-POL_BASE-1:0] pol_sel,
  input  logic                   dir_wr,
  input  logic [CH-1:0]          dir_data,
  input  logic                   dat_wr,
  input  logic [CH-1:0]          dat_data,
  input  logic                   push_n,
  input  logic [CH-1:0]          ack,
  output logic [CH-1:0]          rd_data,
  output logic [CH-1:0]          req_n,
  output logic                   edge3_pulse,
  output logic                   edge4_pulse,
  output logic [CH-1:0]          pad_oe,
  output logic [CH-1:0]          pad_out
);
  localparam int unsigned POL_W = CH - POL_BASE;

  logic [CH-1:0]    pin_s;
  logic [POL_W-1:0] pol_q;
  logic [CH-1:0]    pol_vec;
  logic [CH-1:0]    edge_ev;
  logic [CH-1:0]    latch_q;
  logic [CH-1:0]    clr_wr;
  logic [CH-1:0]    clr_push;
  logic [CH-1:0]    dir_q;
  logic [CH-1:0]    rd_mux;

  ilb_sync #(.WIDTH(CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= '0;
      dir_q <= '0;
    end else begin
      pol_q <= pol_sel;
      if (dir_wr) dir_q <= dir_data;
    end
  end

  ilb_wr_clear #(.WIDTH(CH)) u_wr (
    .clk(clk), .rst(rst), .wr(dat_wr), .wdata(dat_data),
    .data_q(pad_out), .clr(clr_wr)
  );

  assign rd_mux = mode_irq ? latch_q : pin_s;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    if (i < POL_BASE) begin : g_fixed
      assign pol_vec[i] = 1'b0;
    end else begin : g_prog
      assign pol_vec[i] = pol_q[i-POL_BASE];
    end

    ilb_edge_cell u_edge (
      .clk(clk), .rst(rst), .enable(mode_irq),
      .pin_s(pin_s[i]), .pol(pol_vec[i]), .pulse(edge_ev[i])
    );

    assign clr_push[i] = !push_n && (ack[i] != rd_mux[i]);

    ilb_latch_cell u_latch (
      .clk(clk), .rst(rst), .enable(mode_irq), .set_ev(edge_ev[i]),
      .clr_wr(clr_wr[i]), .clr_push(clr_push[i]), .q(latch_q[i])
    );

    assign req_n[i] = req_level_n(latch_q[i], dir_q[i]);
  end

  assign rd_data     = rd_mux;
  assign edge3_pulse = edge_ev[POL_BASE];
  assign edge4_pulse = edge_ev[POL_BASE+1];
  assign pad_oe      = mode_irq ? '0 : dir_q;

  // R10: no request can be pending one clock after plain I/O mode
  assert_req_idle_mode0_R10: assert property (@(posedge clk) disable iff (rst)
    !mode_irq |=> (&req_n));
  // R2: no edge pulse while in plain I/O mode
  assert_no_edge_mode0_R2: assert property (@(posedge clk) disable iff (rst)
    !mode_irq |-> (edge_ev == '0));
  // R12: drivers never enabled in interrupt mode
  assert_pads_off_R12: assert property (@(posedge clk) disable iff (rst)
    mode_irq |-> (pad_oe == '0));
endmodule

// File: tb/intr_latch_bank_tb_top.sv
`timescale 1ns/1ps
module intr_latch_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       mode_irq;
  logic [4:0] pin_in;
  logic [1:0] pol_sel;
  logic       dir_wr;
  logic [4:0] dir_data;
  logic       dat_wr;
  logic [4:0] dat_data;
  logic       push_n;
  logic [4:0] ack;
  logic [4:0] rd_data;
  logic [4:0] req_n;
  logic       edge3_pulse;
  logic       edge4_pulse;
  logic [4:0] pad_oe;
  logic [4:0] pad_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  intr_latch_bank dut_i (
    .clk(clk), .rst(rst), .mode_irq(mode_irq), .pin_in(pin_in),
    .pol_sel(pol_sel), .dir_wr(dir_wr), .dir_data(dir_data),
    .dat_wr(dat_wr), .dat_data(dat_data), .push_n(push_n), .ack(ack),
    .rd_data(rd_data), .req_n(req_n), .edge3_pulse(edge3_pulse),
    .edge4_pulse(edge4_pulse), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic write_data(input logic [4:0] v);
    dat_wr = 1'b1; dat_data = v;
    tick(1);
    dat_wr = 1'b0;
    tick(1);
  endtask

  task automatic write_dir(input logic [4:0] v);
    dir_wr = 1'b1; dir_data = v;
    tick(1);
    dir_wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 req_n after reset", req_n, 5'b11111);
    mode_irq = 1'b1;
    tick(1);
    check("R1 latches after reset", rd_data, 5'b00000);
    mode_irq = 1'b0;
    tick(1);
  endtask

  task automatic t_mode0;
    write_dir(5'b10101);
    check("R12 pad_oe follows dir in mode 0", pad_oe, 5'b10101);
    pin_in = 5'b01010;
    tick(2);
    check("R2 read returns pins in mode 0", rd_data, 5'b01010);
    pin_in = 5'b11111;
    tick(3);
    mode_irq = 1'b1;
    tick(1);
    check("R2 no latch set by mode 0 falls", rd_data, 5'b00000);
    check("R12 pad_oe off in mode 1", pad_oe, 5'b00000);
  endtask

  task automatic t_fall_and_write;
    pin_in = 5'b11110;
    tick(3);
    check("R3 falling ch0 sets latch", rd_data, 5'b00001);
    pin_in = 5'b11100;
    tick(3);
    check("R3 falling ch1 sets latch", rd_data, 5'b00011);
    dat_wr = 1'b1; dat_data = 5'b11101;
    tick(1);
    dat_wr = 1'b0;
    check("R7 no clear while strobe high", rd_data, 5'b00011);
    tick(1);
    check("R7 zero bit clears, one bit keeps", rd_data, 5'b00001);
    check("R12 pad_out holds written data", pad_out, 5'b11101);
    write_data(5'b11110);
    check("R7 write zero clears ch0", rd_data, 5'b00000);
    pin_in = 5'b11111;
    tick(3);
    check("R3 rising pins set nothing", rd_data, 5'b00000);
  endtask

  task automatic t_polarity;
    pol_sel = 2'b01;
    tick(1);
    check("R6 polarity toggle pulses ch3", {3'b0, edge4_pulse, edge3_pulse}, 5'b00001);
    tick(1);
    check("R5 polarity toggle sets ch3", rd_data, 5'b01000);
    check("R6 ch3 pulse gone", {4'b0, edge3_pulse}, 5'b00000);
    pol_sel = 2'b11;
    tick(2);
    check("R5 polarity toggle sets ch4", rd_data, 5'b11000);
    write_data(5'b00111);
    check("R7 clear ch3 and ch4", rd_data, 5'b00000);
    pin_in = 5'b00111;
    tick(3);
    check("R4 falling with polarity 1 sets nothing", rd_data, 5'b00000);
    pin_in = 5'b01111;
    tick(2);
    check("R6 rising ch3 pulse", {3'b0, edge4_pulse, edge3_pulse}, 5'b00001);
    tick(1);
    check("R4 rising ch3 sets latch", rd_data, 5'b01000);
    check("R6 single pulse ch3", {4'b0, edge3_pulse}, 5'b00000);
    pin_in = 5'b11111;
    tick(2);
    check("R6 rising ch4 pulse", {3'b0, edge4_pulse, edge3_pulse}, 5'b00010);
    tick(1);
    check("R4 rising ch4 sets latch", rd_data, 5'b11000);
    write_data(5'b00111);
    pol_sel = 2'b00;
    tick(3);
    check("R4 polarity back to 0 when high sets nothing", rd_data, 5'b00000);
  endtask

  task automatic t_push_and_mask;
    pin_in = 5'b11100;
    tick(3);
    check("R3 ch0 and ch1 set", rd_data, 5'b00011);
    ack = 5'b00000;
    tick(2);
    check("R8 ack ignored while push_n high", rd_data, 5'b00011);
    push_n = 1'b0; ack = 5'b00001;
    tick(1);
    push_n = 1'b1;
    check("R8 differing ack clears, equal keeps", rd_data, 5'b00001);
    write_dir(5'b00001);
    check("R10 unmasked request asserted", req_n, 5'b11110);
    write_dir(5'b11110);
    check("R10 masked request idle", req_n, 5'b11111);
  endtask

  task automatic t_set_wins;
    pin_in = 5'b10100;
    tick(3);
    pin_in = 5'b11100;
    tick(3);
    check("R3 ch3 set before race", rd_data, 5'b01001);
    pol_sel = 2'b01;
    tick(1);
    push_n = 1'b0; ack = 5'b00001;
    tick(1);
    push_n = 1'b1;
    check("R9 set beats push clear", rd_data, 5'b01001);
    push_n = 1'b0; ack = 5'b00001;
    tick(1);
    push_n = 1'b1;
    check("R8 push clears ch3 alone", rd_data, 5'b00001);
  endtask

  task automatic t_mode_exit;
    mode_irq = 1'b0;
    tick(1);
    mode_irq = 1'b1;
    tick(1);
    check("R11 leaving mode 1 clears latches", rd_data, 5'b00000);
  endtask

  initial begin
    rst = 1'b1; mode_irq = 1'b0; pin_in = 5'b11111; pol_sel = 2'b00;
    dir_wr = 1'b0; dir_data = '0; dat_wr = 1'b0; dat_data = '0;
    push_n = 1'b1; ack = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_mode0();
    t_fall_and_write();
    t_polarity();
    t_push_and_mask();
    t_set_wins();
    t_mode_exit();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule